// File: doc/BRIEF.md
# Byte-Store Hazard Guard

This block screens every byte store that two competing teams of cores send to a shared, byte-addressed memory. Each store arrives with the writer's core number and team, the target address, the byte to be written and the byte the memory holds at that address at present (read ahead of the write). In the same cycle the block decides whether the write commits, and how many cycles the writing core must stall. Three marker byte values carry special meaning. A trap marker arms the byte it lands on. A disarm marker clears an armed byte. A strike marker opens a short window over one half of memory, and the opposing team pays extra stall cycles for stores into that half while the window is open.

Each team has a limited number of traps and strikes. The block keeps both counts per team and exposes them. It also keeps one strike window per memory half, together with the team that fired it. The topmost region of the address space is protected, and traps have no effect there. Only stores reach this block. Loads never appear at its input, so a load can never set off a trap. The stall timers inside the cores, scoring and end-of-game detection are handled elsewhere.

Top module: `store_guard`

## Requirements
- R1: A valid store of 0xF0 outside the protected region, by a team whose trap count is non-zero, commits, reports a stall of ARM_STALL, and lowers that team's trap count by one.
- R2: A valid store of any byte other than 0xF2 to an address outside the protected region whose current byte is 0xF0 does not commit and reports a stall of HIT_STALL. It changes no count, and it repeats the same way for every later store to that byte.
- R3: A valid store of 0xF2 to an address outside the protected region whose current byte is 0xF0 commits with a stall of FORCE_STALL. A store of 0xF2 to any other byte is plain data.
- R4: The protected region is every address whose bits ADDR_W-1 down to PROT_LG are all ones. There, a store of 0xF0 is plain data with no stall and no change to any count, and a store over a 0xF0 byte commits normally.
- R5: After a team has armed TRAP_QUOTA traps, a further 0xF0 store by that team is plain data with a stall of zero.
- R6: A valid store of 0xF1 by a team whose strike count is non-zero commits and lowers that team's strike count by one. It also opens a window on the half selected by address bit ADDR_W-1. The window covers the WIN_LEN cycles that follow the strike, and it is owned by the striking team. A new strike on a half restarts that half's window.
- R7: While a half's window is open, a committed store into that half by the team that does not own the window has STRIKE_STALL added to its stall. Stores by the owning team, and any store after the window has closed, get no such addition.
- R8: After a team has fired STRIKE_QUOTA strikes, a further 0xF1 store by that team is plain data and opens no window.
- R9: A blocked store (R2) reports exactly HIT_STALL even inside an open window, and it uses no quota. For any other store, the stall is the marker stall (R1 or R3, else zero) plus the window addition (R7).
- R10: After reset, every trap count reads TRAP_QUOTA and every strike count reads STRIKE_QUOTA. With st_valid_i low, commit_o and stall_cycles_o are 0 and no count changes.
- R11: Team t's trap count sits at trap_left_o[t*TQ_W +: TQ_W] and its strike count at strike_left_o[t*SQ_W +: SQ_W]. TQ_W and SQ_W are the bit widths that hold the respective quota. stall_core_o echoes st_core_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | A byte store is presented this cycle |
| st_core_i | input | CORE_W | Number of the core issuing the store |
| st_team_i | input | 1 | Team of the storing core |
| st_addr_i | input | ADDR_W | Byte address of the store |
| st_wdata_i | input | 8 | Byte to be written |
| st_cur_i | input | 8 | Byte currently held at st_addr_i |
| commit_o | output | 1 | The write may proceed to memory |
| stall_core_o | output | CORE_W | Core that the stall length applies to |
| stall_cycles_o | output | STALL_W | Stall length for that core |
| trap_left_o | output | 2*TQ_W | Traps each team has left |
| strike_left_o | output | 2*SQ_W | Strikes each team has left |

## Verification
The hardest states to reach from the ports are the exact last cycle of a strike window, and a store that is trapped and also under an opposing strike at once. Reaching them takes a strike followed by a counted run of idle cycles, and then a store aimed into the struck half over a 0xF0 byte. The bench drives these sequences directly. A long run of mixed stores then follows, in which every marker value, protected and unprotected addresses, both teams and idle gaps all appear. The quotas are kept small so that both kinds run out several times, and a reset is applied part way through. A bench-side model derived from the requirements gives the expected commit, stall and counts for every cycle.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam logic [7:0] BYTE_TRAP  = 8'hF0;
  localparam logic [7:0] BYTE_ION   = 8'hF1;
  localparam logic [7:0] BYTE_FORCE = 8'hF2;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_PLAIN,
    ACT_ARM,
    ACT_DISARM,
    ACT_BLOCKED
  } act_e;
endpackage

// File: rtl/guard_quota.sv
module guard_quota #(
  parameter int QUOTA = 15,
  parameter int W     = $clog2(QUOTA + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         take_i,
  output logic [W-1:0] left_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  left_o <= W'(QUOTA);
    else if (take_i && left_o != '0) left_o <= left_o - 1'b1;
  end

  AST_QUOTA_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> left_o != '0); // R5
  AST_QUOTA_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> left_o <= $past(left_o)); // R8
endmodule

// File: rtl/guard_window.sv
module guard_window #(
  parameter int LEN = 100,
  parameter int W   = $clog2(LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic fire_team_i,
  output logic active_o,
  output logic owner_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      owner_o <= 1'b0;
    end else if (fire_i) begin
      cnt_q   <= W'(LEN);
      owner_o <= fire_team_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = cnt_q != '0;

  AST_WIN_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> active_o && owner_o == $past(fire_team_i)); // R6
  AST_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= W'(LEN)); // R6
endmodule

// File: rtl/guard_classify.sv
module guard_classify
  import guard_pkg::*;
#(
  parameter int STALL_W      = 20,
  parameter int ARM_STALL    = 100,
  parameter int HIT_STALL    = 1000000,
  parameter int FORCE_STALL  = 100,
  parameter int STRIKE_STALL = 300
) (
  input  logic               valid_i,
  input  logic               prot_i,
  input  logic [7:0]         wdata_i,
  input  logic [7:0]         cur_i,
  input  logic               trap_avail_i,
  input  logic               strike_avail_i,
  input  logic               win_hit_i,
  output act_e               act_o,
  output logic               take_trap_o,
  output logic               strike_o,
  output logic               commit_o,
  output logic [STALL_W-1:0] stall_o
);
  logic               armed;
  logic [STALL_W-1:0] base;

  assign armed = cur_i == BYTE_TRAP && !prot_i;

  always_comb begin
    act_o       = ACT_IDLE;
    take_trap_o = 1'b0;
    strike_o    = 1'b0;
    base        = '0;
    if (valid_i) begin
      if (armed) begin
        if (wdata_i == BYTE_FORCE) begin
          act_o = ACT_DISARM;
          base  = STALL_W'(FORCE_STALL);
        end else begin
          act_o = ACT_BLOCKED;
        end
      end else if (wdata_i == BYTE_TRAP && !prot_i && trap_avail_i) begin
        act_o       = ACT_ARM;
        take_trap_o = 1'b1;
        base        = STALL_W'(ARM_STALL);
      end else begin
        act_o    = ACT_PLAIN;
        strike_o = wdata_i == BYTE_ION && strike_avail_i;
      end
    end
  end

  // trapped-write stall overrides everything; others add the window penalty
  always_comb begin
    commit_o = valid_i && act_o != ACT_BLOCKED;
    if (act_o == ACT_BLOCKED)      stall_o = STALL_W'(HIT_STALL);
    else if (valid_i && win_hit_i) stall_o = base + STALL_W'(STRIKE_STALL);
    else                           stall_o = base;
  end
endmodule

// File: rtl/store_guard.sv
module store_guard
  import guard_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int PROT_LG      = 22,
  parameter int CORE_W       = 2,
  parameter int TRAP_QUOTA   = 15,
  parameter int STRIKE_QUOTA = 30,
  parameter int WIN_LEN      = 100,
  parameter int ARM_STALL    = 100,
  parameter int HIT_STALL    = 1000000,
  parameter int FORCE_STALL  = 100,
  parameter int STRIKE_STALL = 300,
  localparam int TQ_W    = $clog2(TRAP_QUOTA + 1),
  localparam int SQ_W    = $clog2(STRIKE_QUOTA + 1),
  localparam int SUM_A   = ARM_STALL + STRIKE_STALL,
  localparam int SUM_F   = FORCE_STALL + STRIKE_STALL,
  localparam int MAX_AF  = SUM_A > SUM_F ? SUM_A : SUM_F,
  localparam int MAX_ST  = MAX_AF > HIT_STALL ? MAX_AF : HIT_STALL,
  localparam int STALL_W = $clog2(MAX_ST + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                st_valid_i,
  input  logic [CORE_W-1:0]   st_core_i,
  input  logic                st_team_i,
  input  logic [ADDR_W-1:0]   st_addr_i,
  input  logic [7:0]          st_wdata_i,
  input  logic [7:0]          st_cur_i,
  output logic                commit_o,
  output logic [CORE_W-1:0]   stall_core_o,
  output logic [STALL_W-1:0]  stall_cycles_o,
  output logic [2*TQ_W-1:0]   trap_left_o,
  output logic [2*SQ_W-1:0]   strike_left_o
);
  localparam int TEAMS = 2;

  logic            prot, half;
  logic [TQ_W-1:0] trap_cnt   [TEAMS];
  logic [SQ_W-1:0] strike_cnt [TEAMS];
  logic            win_act    [TEAMS];
  logic            win_own    [TEAMS];
  logic            win_hit, take_trap, strike;
  act_e            act;

  assign prot = &st_addr_i[ADDR_W-1:PROT_LG];
  assign half = st_addr_i[ADDR_W-1];
  assign win_hit = win_act[half] && win_own[half] != st_team_i;

  guard_classify #(
    .STALL_W(STALL_W), .ARM_STALL(ARM_STALL), .HIT_STALL(HIT_STALL),
    .FORCE_STALL(FORCE_STALL), .STRIKE_STALL(STRIKE_STALL)
  ) u_classify (
    .valid_i       (st_valid_i),
    .prot_i        (prot),
    .wdata_i       (st_wdata_i),
    .cur_i         (st_cur_i),
    .trap_avail_i  (trap_cnt[st_team_i] != '0),
    .strike_avail_i(strike_cnt[st_team_i] != '0),
    .win_hit_i     (win_hit),
    .act_o         (act),
    .take_trap_o   (take_trap),
    .strike_o      (strike),
    .commit_o      (commit_o),
    .stall_o       (stall_cycles_o)
  );

  for (genvar t = 0; t < TEAMS; t++) begin : g_team
    guard_quota #(.QUOTA(TRAP_QUOTA), .W(TQ_W)) u_trap_q (
      .clk_i, .rst_ni,
      .take_i(take_trap && st_team_i == 1'(t)),
      .left_o(trap_cnt[t])
    );
    guard_quota #(.QUOTA(STRIKE_QUOTA), .W(SQ_W)) u_strike_q (
      .clk_i, .rst_ni,
      .take_i(strike && st_team_i == 1'(t)),
      .left_o(strike_cnt[t])
    );
    assign trap_left_o[t*TQ_W +: TQ_W]   = trap_cnt[t];
    assign strike_left_o[t*SQ_W +: SQ_W] = strike_cnt[t];
  end

  for (genvar h = 0; h < TEAMS; h++) begin : g_half
    guard_window #(.LEN(WIN_LEN)) u_win (
      .clk_i, .rst_ni,
      .fire_i     (strike && half == 1'(h)),
      .fire_team_i(st_team_i),
      .active_o   (win_act[h]),
      .owner_o    (win_own[h])
    );
  end

  assign stall_core_o = st_core_i;

  AST_TRAPPED_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i && st_cur_i == BYTE_TRAP && !prot && st_wdata_i != BYTE_FORCE
    |-> !commit_o && stall_cycles_o == STALL_W'(HIT_STALL)); // R2
  AST_BLOCKED_NO_QUOTA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act == ACT_BLOCKED |=> $stable(trap_left_o) && $stable(strike_left_o)); // R9
  AST_PROT_NO_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i && prot |=> $stable(trap_left_o)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_valid_i |-> !commit_o && stall_cycles_o == '0 ##1 $stable(trap_left_o) && $stable(strike_left_o)); // R10
endmodule

// File: tb/tb_store_guard.sv
module tb_store_guard;
  localparam int ADDR_W = 12, PROT_LG = 8, CORE_W = 2;
  localparam int TQ = 3, SQ = 4, WIN = 5;
  localparam int ARM = 7, HIT = 1000, FRC = 9, STK = 30;
  localparam int TQ_W = $clog2(TQ + 1), SQ_W = $clog2(SQ + 1);
  localparam int SUM_A = ARM + STK, SUM_F = FRC + STK;
  localparam int MAX_AF = SUM_A > SUM_F ? SUM_A : SUM_F;
  localparam int MAX_ST = MAX_AF > HIT ? MAX_AF : HIT;
  localparam int STALL_W = $clog2(MAX_ST + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic st_valid_i = 1'b0, st_team_i = 1'b0;
  logic [CORE_W-1:0] st_core_i = '0;
  logic [ADDR_W-1:0] st_addr_i = '0;
  logic [7:0] st_wdata_i = '0, st_cur_i = '0;
  logic commit_o;
  logic [CORE_W-1:0] stall_core_o;
  logic [STALL_W-1:0] stall_cycles_o;
  logic [2*TQ_W-1:0] trap_left_o;
  logic [2*SQ_W-1:0] strike_left_o;

  int checks = 0, failures = 0;
  int tl_m[2], sl_m[2], wc_m[2];
  bit wo_m[2];
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;

  store_guard #(
    .ADDR_W(ADDR_W), .PROT_LG(PROT_LG), .CORE_W(CORE_W),
    .TRAP_QUOTA(TQ), .STRIKE_QUOTA(SQ), .WIN_LEN(WIN),
    .ARM_STALL(ARM), .HIT_STALL(HIT), .FORCE_STALL(FRC), .STRIKE_STALL(STK)
  ) dut (.*, .clk_i(clk));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_counts(input string req);
    for (int t = 0; t < 2; t++) begin
      chk(trap_left_o[t*TQ_W +: TQ_W] == TQ_W'(tl_m[t]), req, "trap count",
          int'(trap_left_o[t*TQ_W +: TQ_W]), tl_m[t]);
      chk(strike_left_o[t*SQ_W +: SQ_W] == SQ_W'(sl_m[t]), req, "strike count",
          int'(strike_left_o[t*SQ_W +: SQ_W]), sl_m[t]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; st_valid_i = 1'b0;
    for (int t = 0; t < 2; t++) begin
      tl_m[t] = TQ; sl_m[t] = SQ; wc_m[t] = 0; wo_m[t] = 0;
    end
    #5;
    chk_counts("R10");
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic store(input bit v, input bit tm, input logic [ADDR_W-1:0] a,
                       input logic [7:0] wd, input logic [7:0] cur, input string force_req);
    bit prot, armed, hit, blk, strike, arm;
    int h, exp_st, base;
    string req;
    prot = &a[ADDR_W-1:PROT_LG];
    h = int'(a[ADDR_W-1]);
    armed = cur == 8'hF0 && !prot;
    hit = v && wc_m[h] > 0 && wo_m[h] != tm;
    blk = v && armed && wd != 8'hF2;
    arm = v && !armed && wd == 8'hF0 && !prot && tl_m[tm] > 0;
    strike = v && !armed && !arm && wd == 8'hF1 && sl_m[tm] > 0;
    base = 0; req = "R10";
    if (v) begin
      req = "R11";
      if (blk) req = hit ? "R9" : "R2";
      else if (armed) begin base = FRC; req = "R3"; end
      else if (arm) begin base = ARM; req = "R1"; end
      else if (wd == 8'hF0) req = prot ? "R4" : "R5";
      else if (wd == 8'hF1) req = strike ? "R6" : "R8";
      else if (hit) req = "R7";
    end
    exp_st = !v ? 0 : blk ? HIT : base + (hit ? STK : 0);
    if (force_req != "") req = force_req;
    st_valid_i = v; st_team_i = tm; st_addr_i = a; st_wdata_i = wd; st_cur_i = cur;
    st_core_i = CORE_W'(rng[3:0]);
    #5;
    chk(commit_o == (v && !blk), req, "commit", int'(commit_o), int'(v && !blk));
    chk(stall_cycles_o == STALL_W'(exp_st), req, "stall", int'(stall_cycles_o), exp_st);
    chk(stall_core_o == st_core_i, "R11", "stall core", int'(stall_core_o), int'(st_core_i));
    chk_counts(req);
    @(posedge clk);
    if (arm) tl_m[tm]--;
    if (strike) sl_m[tm]--;
    for (int k = 0; k < 2; k++) begin
      if (strike && k == h) begin wc_m[k] = WIN; wo_m[k] = tm; end
      else if (wc_m[k] > 0) wc_m[k]--;
    end
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R10 idle
    store(0, 0, 12'h100, 8'hF0, 8'h00, "R10");
    // R1 arm, R2 repeated hits, R3 disarm
    store(1, 0, 12'h010, 8'hF0, 8'h00, "R1");
    store(1, 1, 12'h010, 8'h33, 8'hF0, "R2");
    store(1, 0, 12'h010, 8'hF1, 8'hF0, "R2");
    store(1, 1, 12'h010, 8'hF2, 8'hF0, "R3");
    store(1, 1, 12'h020, 8'hF2, 8'h44, "R3");
    // R4 protected region
    store(1, 1, 12'hF40, 8'hF0, 8'h00, "R4");
    store(1, 0, 12'hF41, 8'h12, 8'hF0, "R4");
    // R5 exhaust team 1 traps
    for (int i = 0; i < TQ; i++) store(1, 1, 12'h030 + 12'(i), 8'hF0, 8'h00, "R1");
    store(1, 1, 12'h040, 8'hF0, 8'h00, "R5");
    // R6/R7 window on upper half by team 0
    store(1, 0, 12'h900, 8'hF1, 8'h00, "R6");
    store(1, 1, 12'h901, 8'h11, 8'h00, "R7");
    store(1, 0, 12'h902, 8'h11, 8'h00, "R7");
    store(1, 1, 12'h101, 8'h11, 8'h00, "R7");
    store(1, 1, 12'h903, 8'h11, 8'hF0, "R9");
    store(1, 1, 12'h904, 8'hF2, 8'hF0, "R9");
    store(1, 1, 12'h905, 8'h11, 8'h00, "R7");
    store(1, 1, 12'h906, 8'h11, 8'h00, "R7");
    // R6 window boundary: strike, idle WIN-1, store at WIN then WIN+1
    store(1, 1, 12'h200, 8'hF1, 8'h00, "R6");
    for (int i = 0; i < WIN - 1; i++) store(0, 0, 12'h0, 8'h0, 8'h0, "R10");
    store(1, 0, 12'h201, 8'h22, 8'h00, "R6");
    store(1, 0, 12'h202, 8'h22, 8'h00, "R6");
    // R8 exhaust team 0 strikes
    for (int i = 0; i < SQ; i++) store(1, 0, 12'h300, 8'hF1, 8'h00, "R8");
    store(1, 1, 12'h301, 8'h22, 8'h00, "R8");
    // mixed sweep, reset half way
    for (int ph = 0; ph < 2; ph++) begin
      do_reset();
      for (int i = 0; i < 2500; i++) begin
        logic [7:0] wd, cur;
        rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
        case (rng[15:14])
          2'd0: wd = 8'hF0;
          2'd1: wd = 8'hF1;
          2'd2: wd = 8'hF2;
          default: wd = rng[23:16];
        endcase
        cur = rng[25] ? 8'hF0 : rng[31:24];
        store(rng[27:26] != 2'd0, rng[28], rng[11:0] | (rng[29] ? 12'hF00 : 12'h000), wd, cur, "");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule